// File: doc/BRIEF.md
# Antenna-Carrier Control Subchannel Byte Port

This block gives a user direct byte-level access to the control words that a radio link hyperframe reserves for antenna-carrier control, namely subchannels 4 through 7. A hyperframe holds 256 basic frames. Control word X opens basic frame X, and its subchannel number is X mod 64. The framer supplies, for every cycle on each direction, the basic-frame index within the hyperframe and the byte offset within the basic frame of byte lane 0. The control word occupies the first `CW_BYTES` bytes of each basic frame.

On the receive side the block copies the frame bytes onto a user data bus, one cycle later, and raises a per-lane valid bit for each lane that holds a byte of a control word in subchannels 4 to 7. The receive side has no back-pressure: the user must take every flagged byte in the cycle it appears. Valid stays low while the framer reports no hyperframe lock.

On the transmit side the block delays the outgoing frame. It raises a per-lane ready bit `WR_LAT` cycles after the framer presents a matching control byte position. The user answers in the next cycle with per-lane valid and data. A lane is written only when its ready was high in the previous cycle and its valid is high now. A ready lane left without valid is filled with zero. All other bytes pass through unchanged. The frame leaves `WR_LAT + 2` cycles after it entered. The user cannot stall the frame: any write offer that is not accepted is simply dropped.

Top module: `cpri_ctl_sub_port`

## Requirements
- R1: A lane is flagged (receive valid or transmit ready) only when the basic-frame index mod 64 is 4, 5, 6 or 7.
- R2: When the receive side is locked, receive valid bit n in cycle t+1 is set exactly when lane n in cycle t is a control-word byte of subchannels 4 to 7. The receive data bus in cycle t+1 equals the frame data of cycle t.
- R3: Receive valid is all zero in any cycle that follows a cycle with the lock input low.
- R4: Transmit ready bit n is high in cycle t+WR_LAT exactly when lane n in cycle t is a control-word byte of subchannels 4 to 7. It is not raised earlier.
- R5: If ready bit n was high in cycle t and valid bit n is high in cycle t+1, byte lane n of the frame output in cycle t+2 equals user data lane n from cycle t+1.
- R6: If ready bit n was high in cycle t and valid bit n is low in cycle t+1, byte lane n of the frame output in cycle t+2 is 8'h00.
- R7: Lanes not granted by ready carry the input frame byte unchanged, delayed by WR_LAT+2 cycles. User valid on such lanes has no effect.
- R8: While reset is high, and in the cycle after, the ready, receive valid, receive data and frame output are all zero.
- R9: Lane n is a control-word byte only if byte_pos + n < CW_BYTES. Lanes at or beyond that offset are never flagged, even in subchannels 4 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock for both directions |
| rst | input | 1 | Synchronous reset, active high |
| rx_frm_data | input | 8*LANES | Received frame bytes, lane 0 at the lowest byte |
| rx_bf_idx | input | 8 | Receive basic-frame index within the hyperframe |
| rx_byte_pos | input | POS_W | Byte offset of lane 0 within the receive basic frame |
| rx_hf_lock | input | 1 | Framer reports hyperframe alignment |
| ctl_rx_data | output | 8*LANES | Frame bytes, one cycle delayed |
| ctl_rx_valid | output | LANES | Per-lane flag for control subchannel bytes |
| tx_frm_data | input | 8*LANES | Outgoing frame bytes before merge |
| tx_bf_idx | input | 8 | Transmit basic-frame index within the hyperframe |
| tx_byte_pos | input | POS_W | Byte offset of lane 0 within the transmit basic frame |
| ctl_tx_ready | output | LANES | Per-lane write grant, user answers next cycle |
| ctl_tx_valid | input | LANES | Per-lane write request |
| ctl_tx_data | input | 8*LANES | User control bytes |
| tx_frm_out | output | 8*LANES | Merged frame, WR_LAT+2 cycles after input |

## Verification
The bench builds the block with eight lanes, a twelve-byte control word and a write latency of 2. This reaches three cases: a full-word hit where every lane is flagged, a partial hit at offset 8 where only the low four lanes qualify, and a miss at offset 16. Basic-frame indices above 63 show that only the low six bits select the subchannel. With a latency of 2, one idle cycle lies between the position and the grant, and the bench checks that ready stays low during it.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int BF_W         = 8;
  localparam int SUBCH_PERIOD = 64;
  localparam int SUBCH_FIRST  = 4;
  localparam int SUBCH_LAST   = 7;
endpackage

// File: rtl/cs_lane_map.sv
// Decides, per byte lane, whether the lane holds a control-word byte
// of an antenna-carrier control subchannel.
module cs_lane_map
  import cs_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int CW_BYTES = 4,
  parameter int POS_W    = 8
) (
  input  logic [BF_W-1:0]  bf_idx,
  input  logic [POS_W-1:0] byte_pos,
  output logic [LANES-1:0] lane_hit
);
  logic [5:0] subch;
  logic       in_sub;

  assign subch  = 6'(bf_idx % BF_W'(SUBCH_PERIOD));
  assign in_sub = (subch >= 6'(SUBCH_FIRST)) && (subch <= 6'(SUBCH_LAST));

  generate
    for (genvar n = 0; n < LANES; n++) begin : g_lane
      assign lane_hit[n] = in_sub && ((int'(byte_pos) + n) < CW_BYTES);
    end
  endgenerate
endmodule

// File: rtl/cs_rx_extract.sv
// Receive side: one register stage, valid gated by hyperframe lock.
module cs_rx_extract #(
  parameter int LANES = 4,
  localparam int DW   = 8 * LANES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DW-1:0]    frm_data,
  input  logic [LANES-1:0] lane_hit,
  input  logic             hf_lock,
  output logic [DW-1:0]    usr_data,
  output logic [LANES-1:0] usr_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      usr_data  <= '0;
      usr_valid <= '0;
    end else begin
      usr_data  <= frm_data;
      usr_valid <= hf_lock ? lane_hit : '0;
    end
  end
endmodule

// File: rtl/cs_tx_merge.sv
// Transmit side: delays the grant mask by WR_LAT and the frame by
// WR_LAT+1. It then merges user bytes on lanes granted in the previous
// cycle and registers the result.
module cs_tx_merge #(
  parameter int LANES  = 4,
  parameter int WR_LAT = 2,
  localparam int DW    = 8 * LANES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DW-1:0]    frm_in,
  input  logic [LANES-1:0] lane_hit,
  input  logic [LANES-1:0] usr_valid,
  input  logic [DW-1:0]    usr_data,
  output logic [LANES-1:0] usr_ready,
  output logic [DW-1:0]    frm_out
);
  logic [LANES-1:0] grant_pipe [WR_LAT];
  logic [DW-1:0]    frame_pipe [WR_LAT+1];
  logic [LANES-1:0] ready_q;
  logic [DW-1:0]    merged;

  assign usr_ready = grant_pipe[WR_LAT-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WR_LAT; i++) grant_pipe[i] <= '0;
      for (int i = 0; i <= WR_LAT; i++) frame_pipe[i] <= '0;
      ready_q <= '0;
      frm_out <= '0;
    end else begin
      grant_pipe[0] <= lane_hit;
      for (int i = 1; i < WR_LAT; i++) grant_pipe[i] <= grant_pipe[i-1];
      frame_pipe[0] <= frm_in;
      for (int i = 1; i <= WR_LAT; i++) frame_pipe[i] <= frame_pipe[i-1];
      ready_q <= usr_ready;
      frm_out <= merged;
    end
  end

  always_comb begin
    merged = frame_pipe[WR_LAT];
    for (int n = 0; n < LANES; n++) begin
      if (ready_q[n]) merged[n*8 +: 8] = usr_valid[n] ? usr_data[n*8 +: 8] : 8'h00;
    end
  end
endmodule

// File: rtl/cpri_ctl_sub_port.sv
module cpri_ctl_sub_port
  import cs_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int CW_BYTES = 4,
  parameter int WR_LAT   = 2,
  parameter int POS_W    = 8,
  localparam int DW      = 8 * LANES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DW-1:0]    rx_frm_data,
  input  logic [BF_W-1:0]  rx_bf_idx,
  input  logic [POS_W-1:0] rx_byte_pos,
  input  logic             rx_hf_lock,
  output logic [DW-1:0]    ctl_rx_data,
  output logic [LANES-1:0] ctl_rx_valid,
  input  logic [DW-1:0]    tx_frm_data,
  input  logic [BF_W-1:0]  tx_bf_idx,
  input  logic [POS_W-1:0] tx_byte_pos,
  output logic [LANES-1:0] ctl_tx_ready,
  input  logic [LANES-1:0] ctl_tx_valid,
  input  logic [DW-1:0]    ctl_tx_data,
  output logic [DW-1:0]    tx_frm_out
);
  logic [LANES-1:0] rx_hit;
  logic [LANES-1:0] tx_hit;

  cs_lane_map #(.LANES(LANES), .CW_BYTES(CW_BYTES), .POS_W(POS_W)) u_rx_map (
    .bf_idx(rx_bf_idx), .byte_pos(rx_byte_pos), .lane_hit(rx_hit));

  cs_lane_map #(.LANES(LANES), .CW_BYTES(CW_BYTES), .POS_W(POS_W)) u_tx_map (
    .bf_idx(tx_bf_idx), .byte_pos(tx_byte_pos), .lane_hit(tx_hit));

  cs_rx_extract #(.LANES(LANES)) u_rx (
    .clk(clk), .rst(rst), .frm_data(rx_frm_data), .lane_hit(rx_hit),
    .hf_lock(rx_hf_lock), .usr_data(ctl_rx_data), .usr_valid(ctl_rx_valid));

  cs_tx_merge #(.LANES(LANES), .WR_LAT(WR_LAT)) u_tx (
    .clk(clk), .rst(rst), .frm_in(tx_frm_data), .lane_hit(tx_hit),
    .usr_valid(ctl_tx_valid), .usr_data(ctl_tx_data),
    .usr_ready(ctl_tx_ready), .frm_out(tx_frm_out));
endmodule

// File: rtl/cs_port_checker.sv
module cs_port_checker #(
  parameter int LANES = 4,
  localparam int DW   = 8 * LANES
) (
  input logic             clk,
  input logic             rst,
  input logic [DW-1:0]    rx_frm_data,
  input logic [7:0]       rx_bf_idx,
  input logic             rx_hf_lock,
  input logic [DW-1:0]    ctl_rx_data,
  input logic [LANES-1:0] ctl_rx_valid,
  input logic [LANES-1:0] ctl_tx_ready,
  input logic [LANES-1:0] ctl_tx_valid,
  input logic [DW-1:0]    ctl_tx_data,
  input logic [DW-1:0]    tx_frm_out
);
  // R3
  rx_lock_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rx_hf_lock) |-> (ctl_rx_valid == '0));

  // R1
  rx_subch_range_chk: assert property (@(posedge clk) disable iff (rst)
    (|ctl_rx_valid) |-> (($past(rx_bf_idx[5:0]) >= 6'd4) && ($past(rx_bf_idx[5:0]) <= 6'd7)));

  // R2
  rx_data_delay_chk: assert property (@(posedge clk) disable iff (rst)
    (|ctl_rx_valid) |-> (ctl_rx_data == $past(rx_frm_data)));

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> ((ctl_tx_ready == '0) && (ctl_rx_valid == '0) && (tx_frm_out == '0)));

  generate
    for (genvar n = 0; n < LANES; n++) begin : g_lane
      // R5
      tx_commit_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(ctl_tx_ready[n], 2) && $past(ctl_tx_valid[n]))
          |-> (tx_frm_out[n*8 +: 8] == $past(ctl_tx_data[n*8 +: 8])));
      // R6
      tx_zero_fill_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(ctl_tx_ready[n], 2) && !$past(ctl_tx_valid[n]))
          |-> (tx_frm_out[n*8 +: 8] == 8'h00));
    end
  endgenerate
endmodule

bind cpri_ctl_sub_port cs_port_checker #(.LANES(LANES)) u_port_chk (
  .clk(clk), .rst(rst), .rx_frm_data(rx_frm_data), .rx_bf_idx(rx_bf_idx),
  .rx_hf_lock(rx_hf_lock), .ctl_rx_data(ctl_rx_data), .ctl_rx_valid(ctl_rx_valid),
  .ctl_tx_ready(ctl_tx_ready), .ctl_tx_valid(ctl_tx_valid),
  .ctl_tx_data(ctl_tx_data), .tx_frm_out(tx_frm_out));

// File: tb/test_cpri_ctl_sub_port.sv
`timescale 1ns/1ps
module test_cpri_ctl_sub_port;
  localparam int LANES = 8;
  localparam int CWB   = 12;
  localparam int WRL   = 2;
  localparam int DW    = 8 * LANES;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DW-1:0]    rx_frm_data = '0;
  logic [7:0]       rx_bf_idx = '0;
  logic [7:0]       rx_byte_pos = '0;
  logic             rx_hf_lock = 1'b0;
  logic [DW-1:0]    ctl_rx_data;
  logic [LANES-1:0] ctl_rx_valid;
  logic [DW-1:0]    tx_frm_data = '0;
  logic [7:0]       tx_bf_idx = '0;
  logic [7:0]       tx_byte_pos = '0;
  logic [LANES-1:0] ctl_tx_ready;
  logic [LANES-1:0] ctl_tx_valid = '0;
  logic [DW-1:0]    ctl_tx_data = '0;
  logic [DW-1:0]    tx_frm_out;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  cpri_ctl_sub_port #(.LANES(LANES), .CW_BYTES(CWB), .WR_LAT(WRL), .POS_W(8)) i_cpri_ctl_sub_port (
    .clk(clk), .rst(rst), .rx_frm_data(rx_frm_data), .rx_bf_idx(rx_bf_idx),
    .rx_byte_pos(rx_byte_pos), .rx_hf_lock(rx_hf_lock), .ctl_rx_data(ctl_rx_data),
    .ctl_rx_valid(ctl_rx_valid), .tx_frm_data(tx_frm_data), .tx_bf_idx(tx_bf_idx),
    .tx_byte_pos(tx_byte_pos), .ctl_tx_ready(ctl_tx_ready), .ctl_tx_valid(ctl_tx_valid),
    .ctl_tx_data(ctl_tx_data), .tx_frm_out(tx_frm_out));

  function automatic logic [LANES-1:0] want_mask(input int bf, input int pos);
    logic [LANES-1:0] m = '0;
    int sc = bf % 64;
    for (int n = 0; n < LANES; n++) m[n] = (sc >= 4) && (sc <= 7) && (pos + n < CWB);
    return m;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(ctl_rx_valid == '0, "R8 rx_valid", 64'(ctl_rx_valid), 64'h0);
    chk(ctl_tx_ready == '0, "R8 tx_ready", 64'(ctl_tx_ready), 64'h0);
    chk(tx_frm_out == '0, "R8 tx_frm_out", tx_frm_out, 64'h0);
    chk(ctl_rx_data == '0, "R8 rx_data", ctl_rx_data, 64'h0);
  endtask

  task automatic t_rx(input int bf, input int pos, input bit lock, input logic [DW-1:0] d, input string req);
    logic [LANES-1:0] exp;
    @(negedge clk);
    rx_bf_idx = 8'(bf); rx_byte_pos = 8'(pos); rx_hf_lock = lock; rx_frm_data = d;
    exp = lock ? want_mask(bf, pos) : '0;
    @(negedge clk);
    chk(ctl_rx_valid == exp, req, 64'(ctl_rx_valid), 64'(exp));
    chk(ctl_rx_data == d, {req, " R2 data"}, ctl_rx_data, d);
  endtask

  task automatic t_tx(input int bf, input int pos, input logic [DW-1:0] frm,
                      input logic [LANES-1:0] vld, input logic [DW-1:0] ud, input string req);
    logic [LANES-1:0] exp_rdy;
    logic [DW-1:0] exp_out;
    logic [DW-1:0] filler;
    filler = ~frm;
    exp_rdy = want_mask(bf, pos);
    @(negedge clk);
    tx_bf_idx = 8'(bf); tx_byte_pos = 8'(pos); tx_frm_data = frm;
    @(negedge clk);
    tx_bf_idx = 8'd0; tx_byte_pos = 8'd0; tx_frm_data = filler;
    chk(ctl_tx_ready == '0, {req, " R4 early"}, 64'(ctl_tx_ready), 64'h0);
    @(negedge clk);
    chk(ctl_tx_ready == exp_rdy, {req, " R4 ready"}, 64'(ctl_tx_ready), 64'(exp_rdy));
    @(negedge clk);
    ctl_tx_valid = vld; ctl_tx_data = ud;
    @(negedge clk);
    exp_out = frm;
    for (int n = 0; n < LANES; n++)
      if (exp_rdy[n]) exp_out[n*8 +: 8] = vld[n] ? ud[n*8 +: 8] : 8'h00;
    chk(tx_frm_out == exp_out, {req, " R5 R6 merge"}, tx_frm_out, exp_out);
    // valid offered without a grant in the previous cycle: R7
    ctl_tx_valid = '1; ctl_tx_data = ~ud;
    @(negedge clk);
    chk(tx_frm_out == filler, {req, " R7 ignored"}, tx_frm_out, filler);
    ctl_tx_valid = '0; ctl_tx_data = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_reset();
    t_rx(5, 0, 1'b0, 64'h1122334455667788, "R3 unlocked");
    t_rx(4, 0, 1'b1, 64'h0102030405060708, "R2 full word");
    t_rx(68, 8, 1'b1, 64'hA1A2A3A4A5A6A7A8, "R9 partial");
    t_rx(7, 16, 1'b1, 64'hB1B2B3B4B5B6B7B8, "R9 beyond");
    t_rx(8, 0, 1'b1, 64'hC1C2C3C4C5C6C7C8, "R1 subch8");
    t_rx(3, 0, 1'b1, 64'hD1D2D3D4D5D6D7D8, "R1 subch3");
    t_rx(255, 0, 1'b1, 64'hE1E2E3E4E5E6E7E8, "R1 subch63");
    t_rx(135, 0, 1'b1, 64'hF1F2F3F4F5F6F7F8, "R1 subch7 upper");
    t_tx(4, 0, 64'h1111111111111111, 8'hFF, 64'h8877665544332211, "R5 full");
    t_tx(6, 8, 64'h2222222222222222, 8'h05, 64'h99AABBCCDDEEFF00, "R6 partial");
    t_tx(9, 0, 64'h3333333333333333, 8'hFF, 64'h0123456789ABCDEF, "R1 R7 nonsub");
    t_tx(71, 0, 64'h4444444444444444, 8'hAA, 64'hFEDCBA9876543210, "R9 R5 mixed");
    t_tx(5, 16, 64'h5555555555555555, 8'hFF, 64'h6666666666666666, "R9 tx beyond");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    failures++;
    checks++;
    $display("FAIL watchdog actual=%h expected=%h", 64'h0, 64'h1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule